// File: doc/BRIEF.md
# Wiper Position Counter with One-Hot Tap Select

This block keeps the tap position of one digitally controlled resistor channel and turns it into a set of tap-enable lines. Exactly one line is high once the block is running. It is placed next to the resistor string: the tap-enable lines drive the switches. The readback value goes to whatever serial front end serves the host.

The position can change in four ways. The host can write it directly. It can be loaded in parallel from one of the channel's nonvolatile data registers. It can move up or down one tap per step request. It is also loaded automatically from data register 0 when reset is released. When several requests arrive in the same cycle, a fixed priority decides which one takes effect. Steps stop at the ends of the string and do not wrap.

Top module: `wiper_counter`

## Requirements
- R1: At most one bit of `tap_en` is high in any cycle, and exactly one is high once the first load after reset has reached the outputs.
- R2: A step with `step_up` = 1 raises the position by one tap, toward the high terminal. Bit index 63 of `tap_en` is the high end.
- R3: A step with `step_up` = 0 lowers the position by one tap, toward the low terminal. Bit index 0 of `tap_en` is the low end.
- R4: A step up at position 63 leaves the position at 63, and a step down at position 0 leaves it at 0.
- R5: A host write loads `host_wr_data` into the position at the next clock edge.
- R6: A bank load with `bank_sel` = k loads data register k, which is bits [6k+5:6k] of `bank_vals`.
- R7: Requests in one cycle are resolved in this order: initial load, then host write, then bank load, then step. Lower-priority requests in that cycle are dropped.
- R8: While `rst_n` is low at a clock edge, the position clears to 0 and all `tap_en` bits are low. At the first edge with `rst_n` high, the position loads data register 0 and every other request in that cycle is ignored.
- R9: `wiper_rdbk` always shows two zero bits above the six position bits, and `wiper_pos` shows the position. Both change at the edge that updates the position.
- R10: `tap_en` selects the position held after the previous edge, so it lags the position by one clock. It stays all-low through the cycle of the initial load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr_en | input | 1 | Direct host write request |
| host_wr_data | input | 6 | Value for a direct host write |
| bank_ld_en | input | 1 | Parallel load request from a data register |
| bank_sel | input | 2 | Index of the data register to load |
| bank_vals | input | 24 | The four data registers, register k in bits [6k+5:6k] |
| step_en | input | 1 | Single-tap step request |
| step_up | input | 1 | Step direction: 1 toward high, 0 toward low |
| wiper_pos | output | 6 | Current position |
| wiper_rdbk | output | 8 | Readback byte with the position zero-extended |
| tap_en | output | 64 | One-hot tap switch enables |

## Verification
The bench builds the block with its default parameters: six position bits, 64 taps and four data registers. With these values both saturation ends (63 and 0) can be reached with a single host write followed by a few steps. Every data register index can be selected, so loads from all four registers are compared against distinct values. A second reset in the middle of the run, with a different value in register 0, shows that the initial load tracks the current contents of that register.

// File: rtl/wiper_pkg.sv
// Package: shared types for the wiper position counter.
// Assumes: only the counter's own modules import it.
package wiper_pkg;

    // Source that wins the position update in a cycle
    typedef enum logic [2:0] {
        SRC_HOLD = 3'd0,
        SRC_INIT = 3'd1,
        SRC_HOST = 3'd2,
        SRC_BANK = 3'd3,
        SRC_STEP = 3'd4
    } wiper_src_e;

endpackage

// File: rtl/wiper_step.sv
// Module: wiper_step
// Computes the position one tap up or down, and holds it at either end of the
// string (no wraparound).
// Assumes: purely combinational; the caller decides whether a step happens.
module wiper_step #(
    parameter int POS_W = 6
) (
    input  logic [POS_W-1:0] cur_pos,
    input  logic             dir_up,
    output logic [POS_W-1:0] step_pos
);
    localparam logic [POS_W-1:0] POS_MAX = '1;
    localparam logic [POS_W-1:0] POS_MIN = '0;

    // Saturating one-tap move in the requested direction
    always_comb begin
        if (dir_up) begin
            step_pos = (cur_pos == POS_MAX) ? cur_pos : POS_W'(cur_pos + 1'b1);
        end else begin
            step_pos = (cur_pos == POS_MIN) ? cur_pos : POS_W'(cur_pos - 1'b1);
        end
    end
endmodule

// File: rtl/wiper_src_sel.sv
// Module: wiper_src_sel
// Priority selection of the next wiper position: initial load, then host
// write, then bank load, then step.
// Assumes: bank_flat packs register k in bits [k*POS_W +: POS_W]; an
// out-of-range bank_sel makes the bank request count as absent.
module wiper_src_sel
    import wiper_pkg::*;
#(
    parameter int POS_W  = 6,
    parameter int NUM_DR = 4,
    localparam int SEL_W = (NUM_DR > 1) ? $clog2(NUM_DR) : 1
) (
    input  logic                    init_req,
    input  logic                    host_wr_en,
    input  logic [POS_W-1:0]        host_wr_data,
    input  logic                    bank_ld_en,
    input  logic [SEL_W-1:0]        bank_sel,
    input  logic [NUM_DR*POS_W-1:0] bank_flat,
    input  logic                    step_en,
    input  logic [POS_W-1:0]        step_pos,
    input  logic [POS_W-1:0]        cur_pos,
    output logic [POS_W-1:0]        nxt_pos,
    output wiper_src_e              nxt_src
);
    logic [POS_W-1:0] bank_arr [NUM_DR];
    logic             sel_ok;

    // Unpack the flat data-register bus into an indexed array
    for (genvar g = 0; g < NUM_DR; g++) begin : g_unpack
        assign bank_arr[g] = bank_flat[g*POS_W +: POS_W];
    end

    // Flag a bank index that points at an existing register
    always_comb sel_ok = (int'(bank_sel) < NUM_DR);

    // Fixed-priority choice of the update source and its value
    always_comb begin
        nxt_pos = cur_pos;
        nxt_src = SRC_HOLD;
        if (init_req) begin
            nxt_pos = bank_arr[0];
            nxt_src = SRC_INIT;
        end else if (host_wr_en) begin
            nxt_pos = host_wr_data;
            nxt_src = SRC_HOST;
        end else if (bank_ld_en && sel_ok) begin
            nxt_pos = bank_arr[bank_sel];
            nxt_src = SRC_BANK;
        end else if (step_en) begin
            nxt_pos = step_pos;
            nxt_src = SRC_STEP;
        end
    end
endmodule

// File: rtl/wiper_tap_decode.sv
// Module: wiper_tap_decode
// Registered decode of the position into one-hot tap enables; every tap is
// off while reset is asserted or before the first load is done.
// Assumes: synchronous active-low reset; pos_valid rises after the initial load.
module wiper_tap_decode #(
    parameter int POS_W = 6,
    localparam int TAPS = 1 << POS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pos_valid,
    input  logic [POS_W-1:0] pos,
    output logic [TAPS-1:0]  tap_en
);
    logic [TAPS-1:0] tap_nxt;

    // One comparator per tap switch
    for (genvar t = 0; t < TAPS; t++) begin : g_tap
        assign tap_nxt[t] = pos_valid && (pos == POS_W'(t));
    end

    // Register the decoded switch enables
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tap_en <= '0;
        end else begin
            tap_en <= tap_nxt;
        end
    end
endmodule

// File: rtl/wiper_counter.sv
// Module: wiper_counter (top)
// Holds the wiper position of one channel. The position is loaded from data
// register 0 after reset, and afterwards changes by host write, bank load or
// saturating step. The top drives readback and registered one-hot tap enables.
// Assumes: synchronous active-low reset; at most one channel per instance.
module wiper_counter
    import wiper_pkg::*;
#(
    parameter int POS_W  = 6,
    parameter int NUM_DR = 4,
    localparam int SEL_W = (NUM_DR > 1) ? $clog2(NUM_DR) : 1,
    localparam int TAPS  = 1 << POS_W,
    localparam int RD_W  = POS_W + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    host_wr_en,
    input  logic [POS_W-1:0]        host_wr_data,
    input  logic                    bank_ld_en,
    input  logic [SEL_W-1:0]        bank_sel,
    input  logic [NUM_DR*POS_W-1:0] bank_vals,
    input  logic                    step_en,
    input  logic                    step_up,
    output logic [POS_W-1:0]        wiper_pos,
    output logic [RD_W-1:0]         wiper_rdbk,
    output logic [TAPS-1:0]         tap_en
);
    logic [POS_W-1:0] pos_q;
    logic             loaded_q;
    logic [POS_W-1:0] step_pos;
    logic [POS_W-1:0] nxt_pos;
    wiper_src_e       nxt_src;

    wiper_step #(.POS_W(POS_W)) u_step (
        .cur_pos  (pos_q),
        .dir_up   (step_up),
        .step_pos (step_pos)
    );

    wiper_src_sel #(.POS_W(POS_W), .NUM_DR(NUM_DR)) u_sel (
        .init_req     (!loaded_q),
        .host_wr_en   (host_wr_en),
        .host_wr_data (host_wr_data),
        .bank_ld_en   (bank_ld_en),
        .bank_sel     (bank_sel),
        .bank_flat    (bank_vals),
        .step_en      (step_en),
        .step_pos     (step_pos),
        .cur_pos      (pos_q),
        .nxt_pos      (nxt_pos),
        .nxt_src      (nxt_src)
    );

    // Position register and the flag that marks the initial load done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q    <= '0;
            loaded_q <= 1'b0;
        end else begin
            if (nxt_src != SRC_HOLD) begin
                pos_q <= nxt_pos;
            end
            loaded_q <= 1'b1;
        end
    end

    wiper_tap_decode #(.POS_W(POS_W)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .pos_valid (loaded_q),
        .pos       (pos_q),
        .tap_en    (tap_en)
    );

    // Readback views of the position
    always_comb begin
        wiper_pos  = pos_q;
        wiper_rdbk = {2'b00, pos_q};
    end
endmodule

// File: rtl/wiper_counter_chk.sv
// Module: wiper_counter_chk
// Assertion checker for wiper_counter, bound to every instance of it.
// Assumes: it sees only the top-level ports; "armed" marks cycles after the
// initial load edge.
module wiper_counter_chk #(
    parameter int POS_W  = 6,
    parameter int NUM_DR = 4,
    localparam int SEL_W = (NUM_DR > 1) ? $clog2(NUM_DR) : 1,
    localparam int TAPS  = 1 << POS_W,
    localparam int RD_W  = POS_W + 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    host_wr_en,
    input logic [POS_W-1:0]        host_wr_data,
    input logic                    bank_ld_en,
    input logic [SEL_W-1:0]        bank_sel,
    input logic [NUM_DR*POS_W-1:0] bank_vals,
    input logic                    step_en,
    input logic                    step_up,
    input logic [POS_W-1:0]        wiper_pos,
    input logic [RD_W-1:0]         wiper_rdbk,
    input logic [TAPS-1:0]         tap_en
);
    localparam logic [POS_W-1:0] POS_MAX = '1;
    logic armed;
    logic plain_step;

    // Track whether the initial load edge has passed since reset
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // A step request with no load competing for the cycle
    always_comb plain_step = armed && step_en && !host_wr_en && !bank_ld_en;

    AST_TAP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tap_en)); // R1
    AST_TAP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> tap_en[$past(wiper_pos)]); // R10
    AST_INIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> wiper_pos == $past(bank_vals[POS_W-1:0])); // R8
    AST_HOST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && host_wr_en) |=> wiper_pos == $past(host_wr_data)); // R7
    AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !host_wr_en && bank_ld_en && int'(bank_sel) < NUM_DR)
        |=> wiper_pos == $past(bank_vals[bank_sel*POS_W +: POS_W])); // R6
    AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (plain_step && step_up && wiper_pos != POS_MAX)
        |=> wiper_pos == POS_W'($past(wiper_pos) + 1'b1)); // R2
    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (plain_step && !step_up && wiper_pos != '0)
        |=> wiper_pos == POS_W'($past(wiper_pos) - 1'b1)); // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (plain_step && step_up && wiper_pos == POS_MAX) |=> wiper_pos == POS_MAX); // R4
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (plain_step && !step_up && wiper_pos == '0) |=> wiper_pos == '0); // R4
    AST_RDBK_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        wiper_rdbk[RD_W-1:POS_W] == 2'b00 && wiper_rdbk[POS_W-1:0] == wiper_pos); // R9
endmodule

bind wiper_counter wiper_counter_chk #(.POS_W(POS_W), .NUM_DR(NUM_DR)) u_chk (.*);

// File: tb/wiper_counter_test.sv
// Scoreboard bench for wiper_counter: the driver task applies one cycle of
// stimulus and queues the expected outputs; the monitor checks them after the edge.
module wiper_counter_test;
    localparam int POS_W = 6;
    localparam int NUM_DR = 4;
    localparam int TAPS = 1 << POS_W;

    typedef struct {
        string           tag;
        logic [POS_W-1:0] pos;
        logic [TAPS-1:0]  taps;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_wr_en = 1'b0;
    logic [POS_W-1:0] host_wr_data = '0;
    logic bank_ld_en = 1'b0;
    logic [1:0] bank_sel = '0;
    logic [NUM_DR*POS_W-1:0] bank_vals;
    logic step_en = 1'b0;
    logic step_up = 1'b0;
    logic [POS_W-1:0] wiper_pos;
    logic [POS_W+1:0] wiper_rdbk;
    logic [TAPS-1:0] tap_en;

    int n_checks = 0;
    int n_fail = 0;
    exp_t q[$];
    logic [POS_W-1:0] m_pos = '0;
    logic m_valid = 1'b0;

    wiper_counter uut (.*);

    always #10 clk = ~clk;

    // One cycle of stimulus plus its expected result, from the requirements
    task automatic drive(input logic rst, input logic hw, input logic [POS_W-1:0] hd,
                         input logic dl, input logic [1:0] ds, input logic se,
                         input logic su, input string tag);
        exp_t e;
        logic [TAPS-1:0] one;
        @(negedge clk);
        rst_n = rst; host_wr_en = hw; host_wr_data = hd;
        bank_ld_en = dl; bank_sel = ds; step_en = se; step_up = su;
        one = '0; one[0] = 1'b1;
        if (!rst) begin
            e.taps = '0; m_pos = '0; m_valid = 1'b0;
        end else begin
            e.taps = m_valid ? (one << m_pos) : '0;
            if (!m_valid) begin
                m_pos = bank_vals[POS_W-1:0]; m_valid = 1'b1;
            end else if (hw) m_pos = hd;
            else if (dl) m_pos = bank_vals[ds*POS_W +: POS_W];
            else if (se && su && m_pos != 6'd63) m_pos = m_pos + 1'b1;
            else if (se && !su && m_pos != 6'd0) m_pos = m_pos - 1'b1;
        end
        e.pos = m_pos;
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(input string tag);
        drive(1'b1, 1'b0, '0, 1'b0, 2'd0, 1'b0, 1'b0, tag);
    endtask

    // Monitor: compare each queued item 5 ns after the edge it belongs to
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_checks += 3;
                if (wiper_pos !== e.pos) begin
                    n_fail++;
                    $display("FAIL %s pos: actual %0d expected %0d", e.tag, wiper_pos, e.pos);
                end
                if (wiper_rdbk !== {2'b00, e.pos}) begin
                    n_fail++;
                    $display("FAIL %s/R9 readback: actual %h expected %h", e.tag, wiper_rdbk, {2'b00, e.pos});
                end
                if (tap_en !== e.taps) begin
                    n_fail++;
                    $display("FAIL %s/R1/R10 taps: actual %h expected %h", e.tag, tap_en, e.taps);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual hang expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        bank_vals = {6'd50, 6'd33, 6'd1, 6'd20};
        drive(1'b0, 1'b0, '0, 1'b0, 2'd0, 1'b0, 1'b0, "R8 reset");
        drive(1'b0, 1'b1, 6'd5, 1'b0, 2'd0, 1'b1, 1'b1, "R8 reset");
        // R8/R7: host write during the initial load cycle is dropped
        drive(1'b1, 1'b1, 6'd5, 1'b1, 2'd3, 1'b1, 1'b1, "R8 init");
        idle("R10 lag");
        for (int i = 0; i < 3; i++) drive(1'b1, 1'b0, '0, 1'b0, 2'd0, 1'b1, 1'b1, "R2 up");
        for (int i = 0; i < 2; i++) drive(1'b1, 1'b0, '0, 1'b0, 2'd0, 1'b1, 1'b0, "R3 down");
        drive(1'b1, 1'b1, 6'd62, 1'b0, 2'd0, 1'b0, 1'b0, "R5 write");
        for (int i = 0; i < 3; i++) drive(1'b1, 1'b0, '0, 1'b0, 2'd0, 1'b1, 1'b1, "R4 top");
        drive(1'b1, 1'b1, 6'd1, 1'b0, 2'd0, 1'b0, 1'b0, "R5 write");
        for (int i = 0; i < 3; i++) drive(1'b1, 1'b0, '0, 1'b0, 2'd0, 1'b1, 1'b0, "R4 bottom");
        for (int k = 2; k >= 0; k--) drive(1'b1, 1'b0, '0, 1'b1, 2'(k), 1'b0, 1'b0, "R6 bank");
        drive(1'b1, 1'b0, '0, 1'b1, 2'd3, 1'b0, 1'b0, "R6 bank");
        drive(1'b1, 1'b1, 6'd7, 1'b1, 2'd3, 1'b1, 1'b1, "R7 host over bank");
        drive(1'b1, 1'b0, '0, 1'b1, 2'd2, 1'b1, 1'b1, "R7 bank over step");
        idle("R10 lag");
        drive(1'b0, 1'b0, '0, 1'b0, 2'd0, 1'b0, 1'b0, "R8 reset");
        bank_vals[POS_W-1:0] = 6'd9;
        drive(1'b1, 1'b0, '0, 1'b0, 2'd0, 1'b1, 1'b0, "R8 init");
        idle("R1 onehot");
        idle("R9 readback");
        repeat (3) @(posedge clk);
        #6;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule